// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns a memory-referencing instruction's addressing mode into the byte address the load/store unit will use. It takes a start strobe, a 3-bit mode code, two register specifiers with the values read for them, a 16-bit displacement and an access size, and returns a registered 64-bit operand address with a done pulse. For the two modes that step their base register it also returns the new base value and a write-back enable, so the surrounding pipeline can update the register file in the same cycle the address appears.

Most modes take a single cycle. Memory-indirect mode first reads a pointer from memory through a plain request/valid port (the request is held, with a steady address, until valid is seen) and then presents the fetched word as the operand address. While that fetch is outstanding the block is busy and ignores further start strobes.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode 0 (register indirect) yields the base value unchanged; a register specifier of 0 makes its value read as zero for every mode, whatever value is presented for it.
- R2: Mode 1 (displacement) yields the base value plus the 16-bit displacement sign-extended to 64 bits, wrapping modulo 2^64.
- R3: Mode 2 (indexed) yields base plus index, wrapping modulo 2^64.
- R4: Mode 3 (absolute) yields the sign-extended displacement alone, ignoring both registers.
- R5: Mode 7 (scaled) yields sign-extended displacement plus base plus index times d, where d = 2^size and size is the 2-bit size input (d of 1, 2, 4 or 8 bytes).
- R6: Mode 5 (post-increment) yields the base value as address and base + d as write-back value.
- R7: Mode 6 (pre-decrement) yields base − d both as the address and as the write-back value.
- R8: Mode 4 (memory indirect) raises the memory request one cycle after start with the (gated) base value as read address, holds request and address steady until read valid is seen, then one cycle after read valid pulses done with the read data as address.
- R9: For every mode except 4, done pulses exactly one cycle after an accepted start; starts may be issued on consecutive cycles.
- R10: Write-back enable is high only together with done for modes 5 and 6; on every other done the write-back value is zero and its enable low.
- R11: A start seen while a memory-indirect fetch is outstanding is ignored and produces no done.
- R12: After synchronous reset done, write-back enable and memory request are low and the address output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (accepted when idle) |
| mode | input | 3 | Addressing mode code |
| base_idx | input | 5 | Base register specifier (0 reads as zero) |
| base_val | input | 64 | Value read for the base register |
| index_idx | input | 5 | Index register specifier (0 reads as zero) |
| index_val | input | 64 | Value read for the index register |
| disp | input | 16 | Signed displacement / constant address field |
| size_log2 | input | 2 | Access size as log2 of bytes |
| mem_req | output | 1 | Pointer read request, memory-indirect mode |
| mem_addr | output | 64 | Pointer read address |
| mem_valid | input | 1 | Pointer read data valid |
| mem_rdata | input | 64 | Pointer read data |
| addr_out | output | 64 | Computed operand address |
| wb_val | output | 64 | New base register value |
| wb_en | output | 1 | Base register write-back enable |
| done | output | 1 | Address valid pulse |

## Verification
The properties assume the memory side asserts read valid only while a request is pending and that the mode, register and size inputs are stable in the cycle start is high. The stimulus respects this: the memory model answers only an open request, after a chosen latency of zero to three cycles, and drops valid the next cycle; mode and operands are changed only on the cycle a new start is driven. Starts issued during an outstanding fetch are deliberate, to exercise the ignore rule, and are not entered into the scoreboard.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    EA_REG_IND  = 3'd0,
    EA_DISP     = 3'd1,
    EA_INDEXED  = 3'd2,
    EA_ABS      = 3'd3,
    EA_MEM_IND  = 3'd4,
    EA_POST_INC = 3'd5,
    EA_PRE_DEC  = 3'd6,
    EA_SCALED   = 3'd7
  } ea_mode_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_FETCH = 1'b1
  } ea_state_e;
endpackage

// File: rtl/ea_operand_gate.sv
module ea_operand_gate #(
  parameter int W     = 64,
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     val,
  output logic [W-1:0]     q
);
  // specifier zero stands for the constant-zero register
  always_comb q = (idx == '0) ? '0 : val;
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int SZ_W   = 2
) (
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic [DISP_W-1:0] disp,
  input  logic [SZ_W-1:0]   size_log2,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] wb_val,
  output logic              wb_en,
  output logic              needs_fetch
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_sx;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] index_scaled;
  logic [ADDR_W-1:0] base_dec;
  ea_mode_e          m;

  always_comb begin
    m            = ea_mode_e'(mode);
    disp_sx      = {{EXT_W{disp[DISP_W-1]}}, disp};
    step         = ADDR_W'(1) << size_log2;
    index_scaled = index << size_log2;
    base_dec     = base - step;
  end

  always_comb begin
    ea          = '0;
    wb_val      = '0;
    wb_en       = 1'b0;
    needs_fetch = 1'b0;
    unique case (m)
      EA_REG_IND:  ea = base;
      EA_DISP:     ea = base + disp_sx;
      EA_INDEXED:  ea = base + index;
      EA_ABS:      ea = disp_sx;
      EA_MEM_IND:  begin
        ea          = base;
        needs_fetch = 1'b1;
      end
      EA_POST_INC: begin
        ea     = base;
        wb_val = base + step;
        wb_en  = 1'b1;
      end
      EA_PRE_DEC:  begin
        ea     = base_dec;
        wb_val = base_dec;
        wb_en  = 1'b1;
      end
      EA_SCALED:   ea = disp_sx + base + index_scaled;
      default:     ea = base;
    endcase
  end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] ea,
  input  logic [ADDR_W-1:0] wb_val_i,
  input  logic              wb_en_i,
  input  logic              needs_fetch,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] addr_out,
  output logic [ADDR_W-1:0] wb_val,
  output logic              wb_en,
  output logic              done
);
  ea_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      addr_out <= '0;
      wb_val   <= '0;
      wb_en    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            if (needs_fetch) begin
              mem_req  <= 1'b1;
              mem_addr <= ea;
              state    <= SEQ_FETCH;
            end else begin
              done     <= 1'b1;
              addr_out <= ea;
              wb_val   <= wb_val_i;
              wb_en    <= wb_en_i;
            end
          end
        end
        SEQ_FETCH: begin
          if (mem_valid) begin
            mem_req  <= 1'b0;
            done     <= 1'b1;
            addr_out <= mem_rdata;
            wb_val   <= '0;
            state    <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5,
  parameter int SZ_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [IDX_W-1:0]  index_idx,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [SZ_W-1:0]   size_log2,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] addr_out,
  output logic [ADDR_W-1:0] wb_val,
  output logic              wb_en,
  output logic              done
);
  localparam int NUM_OPS = 2;

  logic [IDX_W-1:0]  op_idx [NUM_OPS];
  logic [ADDR_W-1:0] op_raw [NUM_OPS];
  logic [ADDR_W-1:0] op_val [NUM_OPS];

  always_comb begin
    op_idx[0] = base_idx;
    op_idx[1] = index_idx;
    op_raw[0] = base_val;
    op_raw[1] = index_val;
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_gate
    ea_operand_gate #(.W(ADDR_W), .IDX_W(IDX_W)) u_gate (
      .idx (op_idx[g]),
      .val (op_raw[g]),
      .q   (op_val[g])
    );
  end

  logic [ADDR_W-1:0] calc_ea;
  logic [ADDR_W-1:0] calc_wb;
  logic              calc_wb_en;
  logic              calc_fetch;

  ea_addr_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SZ_W(SZ_W)) u_calc (
    .mode        (mode),
    .base        (op_val[0]),
    .index       (op_val[1]),
    .disp        (disp),
    .size_log2   (size_log2),
    .ea          (calc_ea),
    .wb_val      (calc_wb),
    .wb_en       (calc_wb_en),
    .needs_fetch (calc_fetch)
  );

  ea_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .ea          (calc_ea),
    .wb_val_i    (calc_wb),
    .wb_en_i     (calc_wb_en),
    .needs_fetch (calc_fetch),
    .mem_valid   (mem_valid),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .addr_out    (addr_out),
    .wb_val      (wb_val),
    .wb_en       (wb_en),
    .done        (done)
  );
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk #(
  parameter int ADDR_W = 64,
  parameter int SZ_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        mode,
  input logic [SZ_W-1:0]   size_log2,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] addr_out,
  input logic [ADDR_W-1:0] wb_val,
  input logic              wb_en,
  input logic              done
);
  // R9
  single_cycle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && mode != 3'd4) |=> done);

  // R8
  fetch_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && mode == 3'd4) |=> (mem_req && !done));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R8
  done_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_valid) |=> (done && !mem_req));

  // R11
  no_done_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> !done);

  // R10
  wb_only_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done);

  // R6
  post_inc_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && mode == 3'd5) |=>
      (wb_en && wb_val == addr_out + (ADDR_W'(1) << $past(size_log2))));

  // R7
  pre_dec_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && mode == 3'd6) |=> (wb_en && wb_val == addr_out));
endmodule

bind eff_addr_gen eff_addr_gen_chk #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .mode      (mode),
  .size_log2 (size_log2),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_valid (mem_valid),
  .addr_out  (addr_out),
  .wb_val    (wb_val),
  .wb_en     (wb_en),
  .done      (done)
);

// File: tb/eff_addr_gen_bench.sv
module eff_addr_gen_bench;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    mode = '0;
  logic [4:0]    base_idx = '0;
  logic [AW-1:0] base_val = '0;
  logic [4:0]    index_idx = '0;
  logic [AW-1:0] index_val = '0;
  logic [15:0]   disp = '0;
  logic [1:0]    size_log2 = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_valid = 1'b0;
  logic [AW-1:0] mem_rdata = '0;
  logic [AW-1:0] addr_out;
  logic [AW-1:0] wb_val;
  logic          wb_en;
  logic          done;

  always #4 clk = ~clk;

  eff_addr_gen u_eff_addr_gen (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .base_idx(base_idx), .base_val(base_val),
    .index_idx(index_idx), .index_val(index_val),
    .disp(disp), .size_log2(size_log2),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .addr_out(addr_out), .wb_val(wb_val), .wb_en(wb_en), .done(done)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [AW-1:0] wb;
    logic          wb_en;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  int            n_checks = 0;
  int            n_fail = 0;
  int            mem_lat = 0;
  logic [AW-1:0] exp_fetch = '0;
  logic [63:0]   rng = 64'h9E37_79B9_7F4A_7C15;

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mem_fn(input logic [AW-1:0] a);
    return {a[31:0], a[63:32]} ^ 64'hA5A5_0000_1234_5678;
  endfunction

  function automatic exp_t model(input logic [2:0] m, input logic [4:0] bi,
      input logic [AW-1:0] bv, input logic [4:0] ii, input logic [AW-1:0] iv,
      input logic [15:0] d, input logic [1:0] sz);
    exp_t e;
    logic [AW-1:0] rb, ri, sd, st;
    rb = (bi == 0) ? 64'd0 : bv;
    ri = (ii == 0) ? 64'd0 : iv;
    sd = AW'($signed(d));
    st = 64'd1 << sz;
    e.wb = '0; e.wb_en = 1'b0;
    case (m)
      3'd0: begin e.addr = rb; e.tag = "R1"; end
      3'd1: begin e.addr = rb + sd; e.tag = "R2"; end
      3'd2: begin e.addr = rb + ri; e.tag = "R3"; end
      3'd3: begin e.addr = sd; e.tag = "R4"; end
      3'd4: begin e.addr = mem_fn(rb); e.tag = "R8"; end
      3'd5: begin e.addr = rb; e.wb = rb + st; e.wb_en = 1'b1; e.tag = "R6"; end
      3'd6: begin e.addr = rb - st; e.wb = rb - st; e.wb_en = 1'b1; e.tag = "R7"; end
      default: begin e.addr = sd + rb + ri * st; e.tag = "R5"; end
    endcase
    return e;
  endfunction

  function automatic logic [63:0] next_rng(input logic [63:0] s);
    logic [63:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // Driver: called at a negedge, returns at a negedge
  task automatic issue(input logic [2:0] m, input logic [4:0] bi,
      input logic [AW-1:0] bv, input logic [4:0] ii, input logic [AW-1:0] iv,
      input logic [15:0] d, input logic [1:0] sz, input int lat, input bit poke);
    exp_t e;
    e = model(m, bi, bv, ii, iv, d, sz);
    sb.push_back(e);
    mode = m; base_idx = bi; base_val = bv; index_idx = ii; index_val = iv;
    disp = d; size_log2 = sz; start = 1'b1;
    if (m == 3'd4) begin
      exp_fetch = (bi == 0) ? 64'd0 : bv;
      mem_lat = lat;
    end
    @(negedge clk);
    start = 1'b0;
    if (m != 3'd4) begin
      // R9: done one cycle after start
      chk(done == 1'b1, "R9 done timing", {63'd0, done}, 64'd1);
    end else begin
      chk(done == 1'b0 && mem_req == 1'b1, "R8 request launch",
          {62'd0, mem_req, done}, 64'd2);
      if (poke) begin
        // R11: start during outstanding fetch must be ignored
        mode = 3'd1; base_idx = 5'd3; base_val = 64'h1000; disp = 16'h10;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      while (!done) @(negedge clk);
    end
  endtask

  // Memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_req && !mem_valid) begin
        chk(mem_addr == exp_fetch, "R8 fetch address", mem_addr, exp_fetch);
        for (int k = 0; k < mem_lat; k++) begin
          chk(done == 1'b0, "R11 no done while fetching", {63'd0, done}, 64'd0);
          @(negedge clk);
          chk(mem_req == 1'b1 && mem_addr == exp_fetch, "R8 request held",
              mem_addr, exp_fetch);
        end
        mem_rdata = mem_fn(mem_addr);
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
        mem_rdata = '0;
      end
    end
  end

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R11 unexpected done", addr_out, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(addr_out == e.addr, {e.tag, " address"}, addr_out, e.addr);
          chk(wb_en == e.wb_en, "R10 write-back enable", {63'd0, wb_en},
              {63'd0, e.wb_en});
          chk(wb_val == e.wb, {e.tag, " R10 write-back value"}, wb_val, e.wb);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(done == 0 && wb_en == 0 && mem_req == 0, "R12 reset controls",
        {61'd0, done, wb_en, mem_req}, 64'd0);
    chk(addr_out == 0, "R12 reset address", addr_out, 64'd0);

    // directed corners, back-to-back single-cycle starts
    issue(3'd0, 5'd4, 64'h0000_1234_5678_9ABC, 5'd0, 64'd0, 16'd0, 2'd0, 0, 0);     // R1
    issue(3'd0, 5'd0, 64'hDEAD_BEEF_0000_0001, 5'd0, 64'd0, 16'd0, 2'd0, 0, 0);     // R1 zero spec
    issue(3'd1, 5'd2, 64'h0000_0000_0000_1000, 5'd0, 64'd0, 16'hFFF0, 2'd0, 0, 0);  // R2 negative
    issue(3'd1, 5'd0, 64'hFFFF_0000_0000_0000, 5'd0, 64'd0, 16'h7FFF, 2'd0, 0, 0);  // R2 as absolute
    issue(3'd2, 5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'd9, 64'd2, 16'd0, 2'd0, 0, 0);     // R3 wrap
    issue(3'd2, 5'd1, 64'h100, 5'd0, 64'h55, 16'd0, 2'd0, 0, 0);                    // R3 zero index
    issue(3'd3, 5'd7, 64'h1111, 5'd8, 64'h2222, 16'h8000, 2'd0, 0, 0);              // R4
    issue(3'd7, 5'd3, 64'h2000, 5'd5, 64'h3, 16'hFFFC, 2'd3, 0, 0);                 // R5 d=8
    issue(3'd7, 5'd3, 64'h2000, 5'd5, 64'h3, 16'h0004, 2'd1, 0, 0);                 // R5 d=2
    issue(3'd5, 5'd6, 64'hFFFF_FFFF_FFFF_FFFC, 5'd0, 64'd0, 16'd0, 2'd2, 0, 0);     // R6 wrap
    issue(3'd5, 5'd6, 64'h40, 5'd0, 64'd0, 16'd0, 2'd0, 0, 0);                      // R6 d=1
    issue(3'd6, 5'd6, 64'h4, 5'd0, 64'd0, 16'd0, 2'd3, 0, 0);                       // R7 below zero
    issue(3'd6, 5'd6, 64'h80, 5'd0, 64'd0, 16'd0, 2'd1, 0, 0);                      // R7
    issue(3'd4, 5'd2, 64'h0000_0000_CAFE_0000, 5'd0, 64'd0, 16'd0, 2'd0, 0, 0);     // R8 lat 0
    issue(3'd4, 5'd2, 64'h0000_0001_0000_0008, 5'd0, 64'd0, 16'd0, 2'd0, 3, 1);     // R8 + R11
    issue(3'd4, 5'd0, 64'h7777_7777_7777_7777, 5'd0, 64'd0, 16'd0, 2'd0, 1, 0);     // R8 zero spec
    issue(3'd6, 5'd1, 64'h1000, 5'd0, 64'd0, 16'd0, 2'd2, 0, 0);                    // R7 after fetch

    // pseudo-random sweep over all modes
    for (int n = 0; n < 300; n++) begin
      logic [63:0] a, b;
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); b = rng;
      issue(a[2:0], a[7:3], b, a[12:8], {b[31:0], a[63:32]}, a[31:16],
            a[34:33], int'(a[36:35]), a[37]);
    end

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R11 scoreboard drained", 64'(sb.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule